// File: doc/BRIEF.md
# Indirect Codec Register Access Port

This block is the host-facing register front end of an audio codec. The host sees four byte-wide ports. An index port selects one of 32 indirect control registers and also holds two control bits. A data port reads and writes the selected register. A status port reports the playback and capture flags and an interrupt flag. A fourth port is reserved for polled transfers and returns zero.

Two indirect registers hold the sample format and the interface configuration. They are protected by a mode-change-enable bit in the index port. While that bit is set, the block mutes the DAC and the protected registers can be written. A playback sample counter raises the interrupt. A transfer-request-disable bit chooses between two behaviours once the interrupt is pending: stop DMA requests, or keep them running for auto-restart transfers. After reset, and during software power-down, the block reports busy and the data port is locked.

The controller has four states. `ST_INIT` is the busy phase after reset or wake-up. `ST_RUN` is normal operation. `ST_MODE` applies while mode-change-enable is set. `ST_PDOWN` is software power-down. The transitions are as follows:
- INIT→RUN or INIT→MODE when the init count expires, chosen by the mode bit.
- RUN→MODE when the mode bit rises, and MODE→RUN when it falls.
- RUN or MODE→PDOWN when the power-down bit is set.
- PDOWN→INIT on any index-port write.

Top module: `codec_idx_port`

## Requirements
- R1: After reset the block is busy for INIT_CYCLES clock cycles. During that time index-port bit 7 reads 1 and the data port reads 0x80. Afterwards bit 7 reads 0.
- R2: The index port (offset 0) reads back as {busy, mode-change-enable, transfer-request-disable, index[4:0]}, at bit positions 7, 6, 5 and 4:0. Bit 7 cannot be written.
- R3: The data port (offset 1) reads the indirect register chosen by the index. A write to it stores the byte there, for every register that R5 does not gate.
- R4: While the block is busy, writes to the data port are ignored and the port reads 0x80. Busy covers the init phase and power-down. Power-down is entered by writing 1 to bit 7 of indirect register 10. Any index-port write during power-down restarts the init phase and clears that bit.
- R5: While mode-change-enable is 0, a write to register 8 leaves it unchanged. A write to register 9 changes only its bits 1:0.
- R6: dac_mute is 1 whenever mode-change-enable is 1, or bit 7 of indirect register 6 is 1.
- R7: The status port (offset 2) reads bit 0 as interrupt active, bit 1 as playback ready (equal to playback enable), bit 2 as playback left/right phase and bit 5 as capture ready (equal to capture enable). Bits 7, 6, 4 and 3 read 0. The phase starts at 0 and toggles on each counted sample.
- R8: The sample counter loads {reg14, reg15}, with register 14 as the high byte, while playback is disabled. Samples count while playback is enabled in the running state. The interrupt sets on the sample after the count reaches zero, that is on the (base+1)-th sample, and the counter reloads. irq follows the interrupt bit.
- R9: Any write to the status port clears the interrupt bit.
- R10: drq is 1 when playback is enabled in the running state, unless transfer-request-disable and the interrupt bit are both 1.
- R11: play_en and capt_en follow bits 0 and 1 of register 9.
- R12: The polled port (offset 3) reads 0x00, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 2 | Port select |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for host_addr, combinational |
| sample_tick | input | 1 | One playback sample consumed |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | DMA request |
| dac_mute | output | 1 | DAC mute |
| play_en | output | 1 | Playback enable |
| capt_en | output | 1 | Capture enable |

## Verification
Reads are combinational, so a port value is due in the same cycle its address is presented. A register or index write is visible right after the edge that captures it. State-derived results (busy after a power-down write, drq gating) settle one edge later, and irq appears on the edge that captures the counted sample. The bench drives on the falling edge and samples 1 ns later. After any write that changes state it waits at least two edges before reading. Across the init phase it waits more than INIT_CYCLES.

// File: rtl/cport_pkg.sv
package cport_pkg;
    typedef enum logic [1:0] {ST_INIT, ST_RUN, ST_MODE, ST_PDOWN} cport_state_e;

    localparam logic [1:0] PORT_INDEX  = 2'd0;
    localparam logic [1:0] PORT_DATA   = 2'd1;
    localparam logic [1:0] PORT_STATUS = 2'd2;
    localparam logic [1:0] PORT_POLL   = 2'd3;

    localparam int unsigned IDX_W      = 5;
    localparam int unsigned REG_OUTVOL = 6;
    localparam int unsigned REG_FMT    = 8;
    localparam int unsigned REG_IFCFG  = 9;
    localparam int unsigned REG_PWR    = 10;
    localparam int unsigned REG_CNT_HI = 14;
    localparam int unsigned REG_CNT_LO = 15;

    localparam logic [7:0] BUSY_CODE = 8'h80;
endpackage

// File: rtl/cport_fsm.sv
module cport_fsm
    import cport_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mce,
    input  logic pd_req,
    input  logic idx_wr,
    output logic busy,
    output logic running,
    output logic pd_clr
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    cport_state_e state_q, state_d;
    logic [CW-1:0] init_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  init_cnt <= '0;
        else if (state_q != ST_INIT) init_cnt <= '0;
        else                         init_cnt <= init_cnt + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  if (init_cnt == LAST) state_d = mce ? ST_MODE : ST_RUN;
            ST_RUN:   if (pd_req) state_d = ST_PDOWN;
                      else if (mce) state_d = ST_MODE;
            ST_MODE:  if (pd_req) state_d = ST_PDOWN;
                      else if (!mce) state_d = ST_RUN;
            ST_PDOWN: if (idx_wr) state_d = ST_INIT;
            default:  state_d = ST_INIT;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        running = 1'b0;
        pd_clr  = 1'b0;
        unique case (state_q)
            ST_INIT:  busy = 1'b1;
            ST_RUN:   running = 1'b1;
            ST_MODE:  running = 1'b0;
            ST_PDOWN: begin
                busy   = 1'b1;
                pd_clr = idx_wr;
            end
            default:  busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/cport_regbank.sv
module cport_regbank
    import cport_pkg::*;
#(
    parameter int unsigned AW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] sel,
    input  logic [7:0]    wr_data,
    input  logic          gate_open,
    input  logic          pd_clr,
    output logic [7:0]    rd_data,
    output logic          vol_mute,
    output logic          play_bit,
    output logic          capt_bit,
    output logic          pd_bit,
    output logic [15:0]   cnt_base
);
    localparam int unsigned NREG = 1 << AW;

    logic [NREG-1:0][7:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam bit         GATED = (g == REG_FMT) || (g == REG_IFCFG);
        localparam logic [7:0] FREE  = (g == REG_IFCFG) ? 8'h03 : 8'h00;
        logic [7:0] q;
        logic [7:0] wmask;

        assign wmask = (GATED && !gate_open) ? FREE : 8'hFF;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 8'h00;
            else if (pd_clr && (g == REG_PWR))
                q[7] <= 1'b0;
            else if (wr_en && (sel == AW'(g)))
                q <= (wr_data & wmask) | (q & ~wmask);
        end

        assign regs[g] = q;
    end

    assign rd_data  = regs[sel];
    assign vol_mute = regs[REG_OUTVOL][7];
    assign play_bit = regs[REG_IFCFG][0];
    assign capt_bit = regs[REG_IFCFG][1];
    assign pd_bit   = regs[REG_PWR][7];
    assign cnt_base = {regs[REG_CNT_HI], regs[REG_CNT_LO]};
endmodule

// File: rtl/cport_timer.sv
module cport_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             play_en,
    input  logic             running,
    input  logic             tick,
    input  logic [CNT_W-1:0] base,
    input  logic             int_clr,
    output logic             int_q,
    output logic             lr_q
);
    logic [CNT_W-1:0] cnt;
    logic             counted;
    logic             fire;

    assign counted = play_en && running && tick;
    assign fire    = counted && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            lr_q <= 1'b0;
        end else if (!play_en) begin
            cnt  <= base;
            lr_q <= 1'b0;
        end else if (counted) begin
            lr_q <= ~lr_q;
            cnt  <= (cnt == '0) ? base : cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       int_q <= 1'b0;
        else if (fire)    int_q <= 1'b1;
        else if (int_clr) int_q <= 1'b0;
    end
endmodule

// File: rtl/codec_idx_port.sv
module codec_idx_port
    import cport_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 16,
    parameter int unsigned CNT_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       sample_tick,
    output logic       irq,
    output logic       drq,
    output logic       dac_mute,
    output logic       play_en,
    output logic       capt_en
);
    logic             mce_q, trd_q;
    logic [IDX_W-1:0] idx_q;
    logic             idx_wr, data_wr, stat_wr;
    logic             busy, running, pd_clr;
    logic [7:0]       reg_rd;
    logic             vol_mute, play_bit, capt_bit, pd_bit;
    logic [15:0]      cnt_base;
    logic             int_q, lr_q;
    logic [7:0]       status;

    assign idx_wr  = host_wr && (host_addr == PORT_INDEX);
    assign data_wr = host_wr && (host_addr == PORT_DATA) && !busy;
    assign stat_wr = host_wr && (host_addr == PORT_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mce_q <= 1'b0;
            trd_q <= 1'b0;
            idx_q <= '0;
        end else if (idx_wr) begin
            mce_q <= host_wdata[6];
            trd_q <= host_wdata[5];
            idx_q <= host_wdata[IDX_W-1:0];
        end
    end

    cport_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mce     (mce_q),
        .pd_req  (pd_bit),
        .idx_wr  (idx_wr),
        .busy    (busy),
        .running (running),
        .pd_clr  (pd_clr)
    );

    cport_regbank #(.AW(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .sel       (idx_q),
        .wr_data   (host_wdata),
        .gate_open (mce_q),
        .pd_clr    (pd_clr),
        .rd_data   (reg_rd),
        .vol_mute  (vol_mute),
        .play_bit  (play_bit),
        .capt_bit  (capt_bit),
        .pd_bit    (pd_bit),
        .cnt_base  (cnt_base)
    );

    cport_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .play_en (play_bit),
        .running (running),
        .tick    (sample_tick),
        .base    (cnt_base[CNT_W-1:0]),
        .int_clr (stat_wr),
        .int_q   (int_q),
        .lr_q    (lr_q)
    );

    assign status = {2'b00, capt_bit, 2'b00, lr_q, play_bit, int_q};

    always_comb begin
        unique case (host_addr)
            PORT_INDEX:  host_rdata = {busy, mce_q, trd_q, idx_q};
            PORT_DATA:   host_rdata = busy ? BUSY_CODE : reg_rd;
            PORT_STATUS: host_rdata = status;
            PORT_POLL:   host_rdata = 8'h00;
            default:     host_rdata = 8'h00;
        endcase
    end

    assign irq      = int_q;
    assign drq      = play_bit && running && !(trd_q && int_q);
    assign dac_mute = mce_q || vol_mute;
    assign play_en  = play_bit;
    assign capt_en  = capt_bit;
endmodule

// File: rtl/codec_idx_port_chk.sv
module codec_idx_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic [7:0] host_rdata,
    input logic       sample_tick,
    input logic       irq,
    input logic       drq,
    input logic       dac_mute,
    input logic       busy,
    input logic       mce,
    input logic       trd,
    input logic [4:0] idx,
    input logic [7:0] reg_rd
);
    AST_BUSY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_addr == 2'd0) |-> host_rdata[7]); // R1
    AST_BUSY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_addr == 2'd1) |-> host_rdata == 8'h80); // R4
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1 && idx == 5'd8 && !mce) |=> $stable(reg_rd)); // R5
    AST_MCE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        mce |-> dac_mute); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_tick)); // R8
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && !sample_tick) |=> !irq); // R9
    AST_TRD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (trd && irq) |-> !drq); // R10
    AST_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd3) |-> host_rdata == 8'h00); // R12
endmodule

bind codec_idx_port codec_idx_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rdata  (host_rdata),
    .sample_tick (sample_tick),
    .irq         (irq),
    .drq         (drq),
    .dac_mute    (dac_mute),
    .busy        (busy),
    .mce         (mce_q),
    .trd         (trd_q),
    .idx         (idx_q),
    .reg_rd      (reg_rd)
);

// File: tb/codec_idx_port_tb_top.sv
module codec_idx_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       sample_tick = 1'b0;
    logic       irq, drq, dac_mute, play_en, capt_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] mdl [32];

    always #4 clk = ~clk;

    codec_idx_port #(.INIT_CYCLES(16), .CNT_W(16)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .sample_tick (sample_tick),
        .irq         (irq),
        .drq         (drq),
        .dac_mute    (dac_mute),
        .play_en     (play_en),
        .capt_en     (capt_en)
    );

    function automatic logic [7:0] exp_store(input int idx, input logic [7:0] old,
                                             input logic [7:0] val, input logic mce);
        if (mce) return val;
        if (idx == 8) return old;
        if (idx == 9) return {old[7:2], val[1:0]};
        return val;
    endfunction

    function automatic logic [7:0] exp_index(input logic busy, input logic mce,
                                             input logic trd, input int idx);
        return {busy, mce, trd, 5'(idx)};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1C0DEC));
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: busy phase right after reset
        rd(2'd0, v); chk("R1 busy index", v, 8'h80);
        rd(2'd1, v); chk("R1 busy data", v, 8'h80);
        // R4: data write during init is ignored
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h77);
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R1 busy cleared", v, exp_index(1'b0, 1'b0, 1'b0, 3));
        rd(2'd1, v); chk("R4 init write ignored", v, 8'h00);
        chk("R6 mute after reset", {7'd0, dac_mute}, 8'h00);
        chk("R10 drq after reset", {7'd0, drq}, 8'h00);

        // Random register traffic (R2, R3, R5, R6, R11)
        for (int it = 0; it < 150; it++) begin
            int idx;
            logic mce;
            logic [7:0] val;
            idx = int'($urandom % 32);
            if (idx == 10) idx = 11;
            mce = 1'($urandom % 2);
            val = 8'($urandom);
            wr(2'd0, exp_index(1'b0, mce, 1'b0, idx));
            wr(2'd1, val);
            mdl[idx] = exp_store(idx, mdl[idx], val, mce);
            rd(2'd0, v); chk("R2 index readback", v, exp_index(1'b0, mce, 1'b0, idx));
            rd(2'd1, v);
            chk((idx == 8 || idx == 9) ? "R5 gated readback" : "R3 data readback", v, mdl[idx]);
            chk("R6 dac_mute", {7'd0, dac_mute}, {7'd0, mce | mdl[6][7]});
            chk("R11 enables", {6'd0, capt_en, play_en}, {6'd0, mdl[9][1:0]});
        end

        // R5 directed: register 8 written with MCE set, then blocked
        wr(2'd0, 8'h48);
        wr(2'd1, 8'h11);
        chk("R6 mute while mce", {7'd0, dac_mute}, 8'h01);
        wr(2'd0, 8'h08);
        wr(2'd1, 8'hEE);
        rd(2'd1, v); chk("R5 fmt held without mce", v, 8'h11);
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h80);
        rd(2'd0, v);
        chk("R6 mute by volume bit", {7'd0, dac_mute}, 8'h01);
        wr(2'd1, 8'h00);
        #1 chk("R6 unmuted", {7'd0, dac_mute}, 8'h00);

        // R12: polled port
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R12 polled reads zero", v, 8'h00);
        rd(2'd1, v); chk("R12 write left reg6", v, 8'h00);
        rd(2'd0, v); chk("R12 write left index", v, 8'h06);

        // R8, R7, R9, R10: sample counter and DMA request
        wr(2'd0, 8'h09); wr(2'd1, 8'h00);
        wr(2'd0, 8'h0E); wr(2'd1, 8'h00);
        wr(2'd0, 8'h0F); wr(2'd1, 8'h03);
        wr(2'd0, 8'h09); wr(2'd1, 8'h01);
        repeat (2) @(negedge clk);
        chk("R10 drq running", {7'd0, drq}, 8'h01);
        rd(2'd2, v); chk("R7 status idle play", v, 8'h02);
        tick(); tick();
        rd(2'd2, v); chk("R7 lr phase after two", v, 8'h02);
        tick();
        chk("R8 no irq after base ticks", {7'd0, irq}, 8'h00);
        rd(2'd2, v); chk("R7 lr phase odd", v, 8'h06);
        tick();
        chk("R8 irq on base+1 tick", {7'd0, irq}, 8'h01);
        rd(2'd2, v); chk("R7 status with int", v, 8'h03);
        chk("R10 drq continues trd=0", {7'd0, drq}, 8'h01);
        wr(2'd0, 8'h29);
        #1 chk("R10 drq stopped by trd", {7'd0, drq}, 8'h00);
        wr(2'd2, 8'h00);
        #1 chk("R9 status write clears irq", {7'd0, irq}, 8'h00);
        chk("R10 drq resumes", {7'd0, drq}, 8'h01);
        tick();
        rd(2'd2, v); chk("R7 status after clear", v, 8'h06);
        tick(); tick(); tick();
        chk("R8 irq after reload", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h5A);
        wr(2'd0, 8'h09); wr(2'd1, 8'h02);
        rd(2'd2, v); chk("R7 capture ready", v, 8'h20);

        // R4: software power-down
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h80);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R4 pdown busy index", v, 8'h8A);
        rd(2'd1, v); chk("R4 pdown data code", v, 8'h80);
        wr(2'd1, 8'h7F);
        wr(2'd0, 8'h0A);
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R4 woke from pdown", v, 8'h0A);
        rd(2'd1, v); chk("R4 pdown write ignored", v, 8'h00);

        finish_run();
    end
endmodule